// File: doc/BRIEF.md
# Phase-Aligned Wrapping Timestamp Counter

This block keeps a free-running counter that advances once per clock and wraps at a configurable top value. With the default settings it is 16 bits wide, runs from a 16 MHz clock, wraps near 244 times per second, and has a resolution of 62.5 ns. A local event strobe takes a snapshot of the count, which serves as the local receive time. Afterwards a remote node's timestamp arrives on a valid-qualified input. The block adds a fixed transmit-path latency constant to that timestamp and finds the modular distance from the snapshot.

If the distance shows that the two counters disagree, the block loads a compare value. When the count reaches that value, the next count is zero, which moves the counter's phase to match the remote node. The compare path then disarms itself, so each request clears the counter only once. A level output flips on every natural wrap, so that the phase of two instances can be compared on a scope.

Top module: `tsync_timer`

## Requirements
- R1: After reset the count rises by one on each clock, never exceeds MAX_VAL, and goes from MAX_VAL to 0.
- R2: While reset is high, the count, the snapshot output and the wrap toggle are all 0, and no correction is pending.
- R3: A high `snap_stb` stores the current count into `snap_ts`, where it is visible one clock later. Without the strobe, `snap_ts` holds its value.
- R4: The adjusted remote time is (`peer_ts` + CHAIN_DLY) modulo (MAX_VAL+1).
- R5: With L the snapshot and P the adjusted remote time, the offset is MAX_VAL − L + P when L > P, and P − L otherwise.
- R6: An offset of 0 or of MAX_VAL arms nothing and leaves any pending correction untouched.
- R7: Any other offset arms a compare value of MAX_VAL − offset. On the clock after the count equals the armed value, the count is 0 instead of count+1.
- R8: An armed correction fires once and then disarms, so it does not clear the count again on later laps.
- R9: A new request replaces a pending compare value. If a request lands on the same clock as a match, the match still clears the count and the new value stays armed.
- R10: `wrap_tgl` flips on each clock where the count goes from MAX_VAL to 0, and holds its value on every other clock.
- R11: A request that arrives on the same clock as `snap_stb` uses the snapshot stored before that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst | input | 1 | Synchronous active-high reset |
| snap_stb | input | 1 | Take a snapshot of the count |
| peer_vld | input | 1 | Remote timestamp valid, one-clock pulse |
| peer_ts | input | CNT_W | Remote counter value |
| count | output | CNT_W | Running count |
| snap_ts | output | CNT_W | Last snapshot |
| wrap_tgl | output | 1 | Flips on each natural wrap |

## Verification
The hardest case to reach from the ports is a new request that lands on the exact clock where a pending compare matches. In that case the clear and the re-arm must both take effect. The bench builds this case by arming a correction first. It then follows the count at the ports until the count equals the compare value that its own model predicts, and strobes a second timestamp on that clock. A sweep of snapshot phases against remote values covers both branches of the offset formula and the modulo step of the latency addition. Directed cases produce the two in-sync offsets.

// File: rtl/tsync_pkg.sv
package tsync_pkg;

  // remote time plus path latency, folded into 0..maxv (dly <= maxv)
  function automatic int unsigned adj_peer(int unsigned peer, int unsigned dly,
                                           int unsigned maxv);
    int unsigned s;
    s = peer + dly;
    if (s > maxv) s = s - (maxv + 1);
    return s;
  endfunction

  // modular distance from local snapshot to adjusted remote time
  function automatic int unsigned wrap_offset(int unsigned loc, int unsigned peer,
                                              int unsigned maxv);
    if (loc > peer) return maxv - loc + peer;
    return peer - loc;
  endfunction

endpackage

// File: rtl/tsync_counter.sv
module tsync_counter #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned MAX_VAL = 65535
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic             tgl
);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_VAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      tgl <= 1'b0;
    end else if (cnt == MAX_C) begin
      cnt <= '0;
      tgl <= ~tgl;
    end else if (clr) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tsync_capture.sv
module tsync_capture #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stb,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] snap
);
  always_ff @(posedge clk) begin
    if (rst)      snap <= '0;
    else if (stb) snap <= cnt;
  end
endmodule

// File: rtl/tsync_offset.sv
module tsync_offset #(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned MAX_VAL   = 65535,
  parameter int unsigned CHAIN_DLY = 0
) (
  input  logic [CNT_W-1:0] snap,
  input  logic [CNT_W-1:0] peer,
  output logic [CNT_W-1:0] off,
  output logic             need_fix
);
  import tsync_pkg::*;

  int unsigned loc_u, peer_u, adj_u, off_u;

  always_comb begin
    loc_u    = 32'(snap);
    peer_u   = 32'(peer);
    adj_u    = adj_peer(peer_u, CHAIN_DLY, MAX_VAL);
    off_u    = wrap_offset(loc_u, adj_u, MAX_VAL);
    off      = CNT_W'(off_u);
    need_fix = (off_u != 0) && (off_u != MAX_VAL);
  end
endmodule

// File: rtl/tsync_arm.sv
module tsync_arm #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             match,
  output logic             armed,
  output logic [CNT_W-1:0] cmp
);
  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      cmp   <= '0;
    end else if (load) begin
      armed <= 1'b1;
      cmp   <= load_val;
    end else if (match) begin
      armed <= 1'b0;
    end
  end
endmodule

// File: rtl/tsync_timer.sv
module tsync_timer #(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned MAX_VAL   = 65535,
  parameter int unsigned CHAIN_DLY = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             snap_stb,
  input  logic             peer_vld,
  input  logic [CNT_W-1:0] peer_ts,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] snap_ts,
  output logic             wrap_tgl
);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_VAL);

  logic             armed;
  logic [CNT_W-1:0] cmp;
  logic [CNT_W-1:0] off;
  logic             need_fix;
  logic             match;
  logic             load;

  assign match = armed && (count == cmp);
  assign load  = peer_vld && need_fix;

  tsync_counter #(.CNT_W(CNT_W), .MAX_VAL(MAX_VAL)) u_cnt (
    .clk(clk), .rst(rst), .clr(match), .cnt(count), .tgl(wrap_tgl)
  );

  tsync_capture #(.CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst(rst), .stb(snap_stb), .cnt(count), .snap(snap_ts)
  );

  tsync_offset #(.CNT_W(CNT_W), .MAX_VAL(MAX_VAL), .CHAIN_DLY(CHAIN_DLY)) u_off (
    .snap(snap_ts), .peer(peer_ts), .off(off), .need_fix(need_fix)
  );

  tsync_arm #(.CNT_W(CNT_W)) u_arm (
    .clk(clk), .rst(rst), .load(load), .load_val(MAX_C - off),
    .match(match), .armed(armed), .cmp(cmp)
  );
endmodule

// File: rtl/tsync_timer_chk.sv
module tsync_timer_chk #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned MAX_VAL = 65535
) (
  input logic             clk,
  input logic             rst,
  input logic             snap_stb,
  input logic             peer_vld,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] snap_ts,
  input logic             wrap_tgl,
  input logic             armed,
  input logic [CNT_W-1:0] cmp,
  input logic [CNT_W-1:0] off,
  input logic             match,
  input logic             load
);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_VAL);

  // R1
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    count <= MAX_C);
  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!match && count != MAX_C) |=> count == CNT_W'($past(count) + 1'b1));
  // R1
  count_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (count == MAX_C) |=> count == '0);
  // R7
  match_clear_chk: assert property (@(posedge clk) disable iff (rst)
    match |=> count == '0);
  // R8
  one_shot_chk: assert property (@(posedge clk) disable iff (rst)
    (match && !load) |=> !armed);
  // R3
  snap_take_chk: assert property (@(posedge clk) disable iff (rst)
    snap_stb |=> snap_ts == $past(count));
  // R3
  snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !snap_stb |=> $stable(snap_ts));
  // R10
  tgl_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (count == MAX_C) |=> wrap_tgl != $past(wrap_tgl));
  // R10
  tgl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (count != MAX_C) |=> $stable(wrap_tgl));
  // R6
  in_sync_chk: assert property (@(posedge clk) disable iff (rst)
    (peer_vld && (off == '0 || off == MAX_C) && !match) |=> $stable(armed) && $stable(cmp));
  // R9
  rearm_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> armed && cmp == CNT_W'(MAX_C - $past(off)));
endmodule

bind tsync_timer tsync_timer_chk #(.CNT_W(CNT_W), .MAX_VAL(MAX_VAL)) u_chk (
  .clk(clk), .rst(rst), .snap_stb(snap_stb), .peer_vld(peer_vld),
  .count(count), .snap_ts(snap_ts), .wrap_tgl(wrap_tgl), .armed(armed),
  .cmp(cmp), .off(off), .match(match), .load(load)
);

// File: tb/tb_tsync_timer.sv
module tb_tsync_timer;
  localparam int TW   = 8;
  localparam int TMAX = 199;
  localparam int TD   = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic snap_stb = 1'b0;
  logic peer_vld = 1'b0;
  logic [TW-1:0] peer_ts = '0;
  logic [TW-1:0] count, snap_ts;
  logic wrap_tgl;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit running = 1'b0;
  string cur_req = "R1";

  int m_cnt = 0, m_snap = 0, m_arm = 0, m_cmp = 0, m_tgl = 0;

  always #4 clk = ~clk;

  tsync_timer #(.CNT_W(TW), .MAX_VAL(TMAX), .CHAIN_DLY(TD)) dut (
    .clk(clk), .rst(rst), .snap_stb(snap_stb), .peer_vld(peer_vld),
    .peer_ts(peer_ts), .count(count), .snap_ts(snap_ts), .wrap_tgl(wrap_tgl)
  );

  function automatic int calc_off(int loc, int peer);
    int p;
    p = (peer + TD) % (TMAX + 1);
    if (loc > p) return TMAX - loc + p;
    return p - loc;
  endfunction

  // reference model built from the requirements
  always @(posedge clk) begin
    int o;
    if (rst) begin
      m_cnt <= 0; m_snap <= 0; m_arm <= 0; m_cmp <= 0; m_tgl <= 0;
    end else begin
      if (m_cnt == TMAX) begin m_cnt <= 0; m_tgl <= 1 - m_tgl; end
      else if (m_arm != 0 && m_cnt == m_cmp) m_cnt <= 0;
      else m_cnt <= m_cnt + 1;
      if (snap_stb) m_snap <= m_cnt;
      o = calc_off(m_snap, int'(peer_ts));
      if (peer_vld && o != 0 && o != TMAX) begin
        m_arm <= 1; m_cmp <= TMAX - o;
      end else if (m_arm != 0 && m_cnt == m_cmp) m_arm <= 0;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (running && !rst) begin
      check(cur_req, "count", int'(count), m_cnt);
      check(cur_req, "snap_ts", int'(snap_ts), m_snap);
      check(cur_req, "wrap_tgl", int'(wrap_tgl), m_tgl);
    end
  end

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected below 190000 cycles", cyc);
      finish_up();
    end
  end

  task automatic step(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic take_snap();
    snap_stb = 1'b1; @(negedge clk); snap_stb = 1'b0;
  endtask

  task automatic send_peer(int v);
    peer_ts = TW'(v); peer_vld = 1'b1; @(negedge clk); peer_vld = 1'b0;
  endtask

  initial begin
    int c0;
    step(3);
    // R2 reset state
    check("R2", "count in reset", int'(count), 0);
    check("R2", "snap in reset", int'(snap_ts), 0);
    check("R2", "tgl in reset", int'(wrap_tgl), 0);
    rst = 1'b0;
    running = 1'b1;

    // R1 and R10: free run across several wraps
    cur_req = "R1 R10";
    step(450);
    while (int'(count) != TMAX) step(1);
    c0 = int'(wrap_tgl);
    step(1);
    check("R1", "wrap to zero", int'(count), 0);
    check("R10", "toggle on wrap", int'(wrap_tgl), 1 - c0);

    // R3 snapshot
    cur_req = "R3";
    step(17); c0 = int'(count); take_snap();
    check("R3", "snapshot value", int'(snap_ts), c0);
    step(10);
    check("R3", "snapshot hold", int'(snap_ts), c0);

    // R11 snapshot and request on the same clock
    cur_req = "R11";
    snap_stb = 1'b1; peer_ts = TW'(77); peer_vld = 1'b1; @(negedge clk);
    snap_stb = 1'b0; peer_vld = 1'b0;
    step(205);

    // R4 R5 R7 R8 sweep of snapshot phase against remote value
    cur_req = "R4 R5 R7 R8";
    for (int i = 0; i < 20; i++) begin
      for (int j = 0; j < 20; j++) begin
        step((i * 37 + j * 11) % 23 + 1);
        take_snap();
        step(j % 3);
        send_peer((j * 10 + i * 3) % (TMAX + 1));
        step(205);
      end
    end
    // remote values near the top exercise the modulo of R4
    for (int v = TMAX - TD - 2; v <= TMAX; v++) begin
      step(v % 13 + 1); take_snap(); send_peer(v); step(205);
    end

    // R6 offset zero: no clear, count keeps running
    cur_req = "R6";
    step(9); take_snap();
    send_peer((int'(snap_ts) - TD + TMAX + 1) % (TMAX + 1));
    c0 = int'(count); step(50);
    check("R6", "offset 0 count runs", int'(count), (c0 + 50) % (TMAX + 1));
    // R6 offset MAX: snapshot at 0, adjusted remote at MAX
    while (int'(count) != 0) step(1);
    take_snap();
    check("R6", "snap at zero", int'(snap_ts), 0);
    send_peer(TMAX - TD);
    c0 = int'(count); step(50);
    check("R6", "offset MAX count runs", int'(count), (c0 + 50) % (TMAX + 1));
    // R6 in-sync request leaves pending correction intact
    take_snap(); send_peer((int'(snap_ts) + 40) % (TMAX + 1));
    send_peer((int'(snap_ts) - TD + TMAX + 1) % (TMAX + 1));
    step(205);

    // R9 replacement of a pending value
    cur_req = "R9";
    take_snap(); send_peer((int'(snap_ts) + 30) % (TMAX + 1));
    step(2);
    send_peer((int'(snap_ts) + 90) % (TMAX + 1));
    step(205);
    // R9 request landing on the matching clock
    take_snap(); send_peer((int'(snap_ts) + 60) % (TMAX + 1));
    while (!(m_arm != 0 && int'(count) == m_cmp)) step(1);
    send_peer((int'(snap_ts) + 50) % (TMAX + 1));
    check("R9", "cleared on match", int'(count), 0);
    step(205);

    running = 1'b0;
    finish_up();
  end
endmodule